// File: doc/BRIEF.md
# Hi/Lo Sequential Multiply Unit

This block is the multiply unit that sits next to a processor's integer pipeline. A multiply command carries two WIDTH-bit operands and a mode bit that selects an unsigned or a signed product. The unit forms the full 2*WIDTH-bit product over several cycles. It then writes the upper half into a Hi result register and the lower half into a Lo result register, and both are written on the same clock edge. Two read ports, one for Hi and one for Lo, return the register contents to the general register path when a move-from request is made.

Commands enter through a valid/ready handshake. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a product is being formed. The issuer must hold `cmd_valid` and the command fields steady until the command is taken, and nothing presented while `cmd_ready` is low has any effect.

Each move-from port is a plain request/data pair. If a request is raised while a multiply is in flight, `stall` tells the pipeline to hold until the new product lands. The unit never traps on overflow. It only reports, through `fits_flag`, whether the last product can be represented in WIDTH bits.

Internally, each operand is widened by one bit: zero-extended for an unsigned command and sign-extended for a signed one. One signed Booth recoding engine then serves both modes.

Top module: `hilo_mult_unit`

## Requirements
- R1: After reset, Hi and Lo read zero, `fits_flag` is 1, `cmd_ready` is 1 and `stall` is 0.
- R2: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both 1. After acceptance, `cmd_ready` is 0 for exactly WIDTH+1 cycles and then returns to 1.
- R3: While `cmd_ready` is 0, `cmd_valid` and the command fields are ignored. The product written is that of the accepted command.
- R4: With `cmd_signed` = 0, {Hi, Lo} becomes the unsigned product of `cmd_a` and `cmd_b`.
- R5: With `cmd_signed` = 1, {Hi, Lo} becomes the two's-complement product of `cmd_a` and `cmd_b`, both read as signed.
- R6: Hi and Lo change only on the edge that completes a multiply, and they change together on that edge.
- R7: `hi_rd_data` always equals Hi and `lo_rd_data` always equals Lo. `stall` is 1 exactly when `hi_rd_req` or `lo_rd_req` is 1 while a multiply is in flight (`cmd_ready` = 0).
- R8: After an unsigned multiply, `fits_flag` is 1 exactly when Hi is all zeros, that is, when the product is below 2^WIDTH.
- R9: After a signed multiply, `fits_flag` is 1 exactly when every bit of Hi equals bit WIDTH-1 of Lo, that is, when the product lies in the signed WIDTH-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Multiply command present |
| cmd_ready | output | 1 | Unit can take a command (idle) |
| cmd_signed | input | 1 | 1 = signed multiply, 0 = unsigned |
| cmd_a | input | WIDTH | Multiplicand |
| cmd_b | input | WIDTH | Multiplier |
| hi_rd_req | input | 1 | Move-from-Hi request |
| hi_rd_data | output | WIDTH | Hi register contents |
| lo_rd_req | input | 1 | Move-from-Lo request |
| lo_rd_data | output | WIDTH | Lo register contents |
| stall | output | 1 | Read requested while a multiply is in flight |
| fits_flag | output | 1 | Last product fits in WIDTH bits for its mode |

## Verification
The assertions check several properties on every cycle. An accepted command loads the full iteration count, and a completing step drops the unit back to idle. Hi and Lo hold still on every cycle without a completion. A raised stall always coincides with a busy unit. A set `fits_flag` agrees with the Hi and Lo contents for the recorded mode. The arithmetic can only be shown by the bench's scenarios: the correctness of both products, the exact busy length, the fact that commands offered while busy are ignored, and the stall seen from the read ports. The bench does this with a full sweep of every operand pair in both modes at a 4-bit width.

// File: rtl/hilo_mult_pkg.sv
package hilo_mult_pkg;
  typedef enum logic {
    MUL_UNSIGNED = 1'b0,
    MUL_SIGNED   = 1'b1
  } mul_mode_e;

  typedef enum logic [1:0] {
    BOOTH_HOLD_0 = 2'b00,
    BOOTH_ADD    = 2'b01,
    BOOTH_SUB    = 2'b10,
    BOOTH_HOLD_1 = 2'b11
  } booth_pair_e;
endpackage

// File: rtl/hilo_booth_step.sv
module hilo_booth_step
  import hilo_mult_pkg::*;
#(
  parameter int ACC_W = 10,
  parameter int MQ_W  = 9
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [MQ_W-1:0]  mq_i,
  input  logic             q1_i,
  input  logic [ACC_W-1:0] mcand_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [MQ_W-1:0]  mq_o,
  output logic             q1_o
);
  logic [ACC_W-1:0] sum;
  booth_pair_e      pair;

  always_comb begin
    pair = booth_pair_e'({mq_i[0], q1_i});
    unique case (pair)
      BOOTH_ADD: sum = acc_i + mcand_i;
      BOOTH_SUB: sum = acc_i - mcand_i;
      default:   sum = acc_i;
    endcase
    acc_o = {sum[ACC_W-1], sum[ACC_W-1:1]};
    mq_o  = {sum[0], mq_i[MQ_W-1:1]};
    q1_o  = mq_i[0];
  end
endmodule

// File: rtl/hilo_mult_engine.sv
module hilo_mult_engine
  import hilo_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mul_mode_e        mode,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             busy,
  output logic             done,
  output mul_mode_e        done_mode,
  output logic [2*WIDTH-1:0] product
);
  localparam int EXT_W = WIDTH + 1;
  localparam int ACC_W = WIDTH + 2;
  localparam int ITER  = WIDTH + 1;
  localparam int CNT_W = $clog2(ITER + 1);

  logic [ACC_W-1:0] acc_q, acc_n, mcand_q;
  logic [EXT_W-1:0] mq_q, mq_n;
  logic             q1_q, q1_n;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  mul_mode_e        mode_q;

  logic             ext_a, ext_b;
  logic [ACC_W-1:0] a_wide;
  logic [EXT_W-1:0] b_wide;

  always_comb begin
    ext_a  = (mode == MUL_SIGNED) & opnd_a[WIDTH-1];
    ext_b  = (mode == MUL_SIGNED) & opnd_b[WIDTH-1];
    a_wide = {ext_a, ext_a, opnd_a};
    b_wide = {ext_b, opnd_b};
  end

  hilo_booth_step #(.ACC_W(ACC_W), .MQ_W(EXT_W)) u_step (
    .acc_i   (acc_q),
    .mq_i    (mq_q),
    .q1_i    (q1_q),
    .mcand_i (mcand_q),
    .acc_o   (acc_n),
    .mq_o    (mq_n),
    .q1_o    (q1_n)
  );

  assign done      = busy_q && (cnt_q == CNT_W'(1));
  assign busy      = busy_q;
  assign done_mode = mode_q;
  assign product   = {acc_n[WIDTH-2:0], mq_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      q1_q    <= 1'b0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      mode_q  <= MUL_UNSIGNED;
    end else if (start && !busy_q) begin
      acc_q   <= '0;
      mq_q    <= b_wide;
      q1_q    <= 1'b0;
      mcand_q <= a_wide;
      cnt_q   <= CNT_W'(ITER);
      busy_q  <= 1'b1;
      mode_q  <= mode;
    end else if (busy_q) begin
      acc_q  <= acc_n;
      mq_q   <= mq_n;
      q1_q   <= q1_n;
      cnt_q  <= cnt_q - CNT_W'(1);
      busy_q <= !done;
    end
  end

  // R2: acceptance loads the full iteration count
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && cnt_q == CNT_W'(ITER)));

  // R2: the final step returns the engine to idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R2: the engine stays busy until the count runs out
  a_r2_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
endmodule

// File: rtl/hilo_result_regs.sv
module hilo_result_regs
  import hilo_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done,
  input  mul_mode_e          done_mode,
  input  logic [2*WIDTH-1:0] product,
  output logic [WIDTH-1:0]   hi,
  output logic [WIDTH-1:0]   lo,
  output logic               fits
);
  logic [WIDTH-1:0] hi_q, lo_q, hi_n, lo_n;
  logic             fits_q, fits_n;
  mul_mode_e        last_mode_q;

  always_comb begin
    hi_n = product[2*WIDTH-1:WIDTH];
    lo_n = product[WIDTH-1:0];
    if (done_mode == MUL_SIGNED) fits_n = (hi_n == {WIDTH{lo_n[WIDTH-1]}});
    else                         fits_n = (hi_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q        <= '0;
      lo_q        <= '0;
      fits_q      <= 1'b1;
      last_mode_q <= MUL_UNSIGNED;
    end else if (done) begin
      hi_q        <= hi_n;
      lo_q        <= lo_n;
      fits_q      <= fits_n;
      last_mode_q <= done_mode;
    end
  end

  assign hi   = hi_q;
  assign lo   = lo_q;
  assign fits = fits_q;

  // R6: results hold unless a multiply completes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(hi_q) && $stable(lo_q)));

  // R8: a set flag after unsigned means Hi is clear
  a_r8_fits_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    (fits_q && last_mode_q == MUL_UNSIGNED) |-> (hi_q == '0));

  // R9: a set flag after signed means Hi replicates Lo's sign
  a_r9_fits_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (fits_q && last_mode_q == MUL_SIGNED) |-> (hi_q == {WIDTH{lo_q[WIDTH-1]}}));
endmodule

// File: rtl/hilo_mult_unit.sv
module hilo_mult_unit
  import hilo_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_signed,
  input  logic [WIDTH-1:0] cmd_a,
  input  logic [WIDTH-1:0] cmd_b,
  input  logic             hi_rd_req,
  output logic [WIDTH-1:0] hi_rd_data,
  input  logic             lo_rd_req,
  output logic [WIDTH-1:0] lo_rd_data,
  output logic             stall,
  output logic             fits_flag
);
  logic               eng_busy, eng_done, accept;
  mul_mode_e          eng_mode;
  logic [2*WIDTH-1:0] eng_product;

  assign cmd_ready = !eng_busy;
  assign accept    = cmd_valid && !eng_busy;
  assign stall     = (hi_rd_req || lo_rd_req) && eng_busy;

  hilo_mult_engine #(.WIDTH(WIDTH)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .mode      (mul_mode_e'(cmd_signed)),
    .opnd_a    (cmd_a),
    .opnd_b    (cmd_b),
    .busy      (eng_busy),
    .done      (eng_done),
    .done_mode (eng_mode),
    .product   (eng_product)
  );

  hilo_result_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (eng_done),
    .done_mode (eng_mode),
    .product   (eng_product),
    .hi        (hi_rd_data),
    .lo        (lo_rd_data),
    .fits      (fits_flag)
  );

  // R7: a stall never coincides with a free command slot
  a_r7_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !cmd_ready);

  // R3: offers made while busy leave the results untouched until completion
  a_r3_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !eng_done) |=> ($stable(hi_rd_data) && $stable(lo_rd_data)));
endmodule

// File: tb/tb_hilo_mult_unit.sv
module tb_hilo_mult_unit;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_signed = 1'b0;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic hi_rd_req = 1'b0, lo_rd_req = 1'b0;
  logic cmd_ready, stall, fits_flag;
  logic [W-1:0] hi_rd_data, lo_rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hilo_mult_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_signed(cmd_signed),
    .cmd_a(cmd_a), .cmd_b(cmd_b),
    .hi_rd_req(hi_rd_req), .hi_rd_data(hi_rd_data),
    .lo_rd_req(lo_rd_req), .lo_rd_data(lo_rd_data),
    .stall(stall), .fits_flag(fits_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int as_signed(input int v);
    return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  // Issue one command; returns the number of cycles cmd_ready stayed low.
  task automatic issue(input bit s, input int a, input int b, output int busy_len);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_signed = s;
    cmd_a      = W'(a);
    cmd_b      = W'(b);
    @(negedge clk);
    cmd_valid  = 1'b0;
    busy_len   = 0;
    while (!cmd_ready) begin
      busy_len++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input bit s, input int a, input int b);
    int p, exp_hi, exp_lo, exp_fit;
    if (s) p = as_signed(a) * as_signed(b);
    else   p = a * b;
    exp_lo = p & MASK;
    exp_hi = (p >> W) & MASK;
    if (s) begin
      exp_fit = (p >= -(1 << (W - 1)) && p < (1 << (W - 1))) ? 1 : 0;
      check("R5 hi", int'(hi_rd_data), exp_hi);
      check("R5 lo", int'(lo_rd_data), exp_lo);
      check("R9 fits", int'(fits_flag), exp_fit);
    end else begin
      exp_fit = (p < (1 << W)) ? 1 : 0;
      check("R4 hi", int'(hi_rd_data), exp_hi);
      check("R4 lo", int'(lo_rd_data), exp_lo);
      check("R8 fits", int'(fits_flag), exp_fit);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hi", int'(hi_rd_data), 0);
    check("R1 lo", int'(lo_rd_data), 0);
    check("R1 fits", int'(fits_flag), 1);
    check("R1 ready", int'(cmd_ready), 1);
    hi_rd_req = 1'b1;
    #0;
    check("R1 stall", int'(stall), 0);
    hi_rd_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2 busy length, R7 stall and read data during a multiply, R6 hold
    issue(1'b0, 7, 9, blen);
    check("R2 busy len", blen, W + 1);
    check_result(1'b0, 7, 9);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_signed = 1'b1; cmd_a = 4'd3; cmd_b = 4'd5;
    @(negedge clk);
    cmd_valid = 1'b0;
    lo_rd_req = 1'b1;
    @(negedge clk);
    check("R7 stall lo", int'(stall), 1);
    check("R7 lo data held", int'(lo_rd_data), (7 * 9) & MASK);
    check("R6 hi held", int'(hi_rd_data), ((7 * 9) >> W) & MASK);
    lo_rd_req = 1'b0; hi_rd_req = 1'b1;
    @(negedge clk);
    check("R7 stall hi", int'(stall), 1);
    hi_rd_req = 1'b0;
    #0;
    check("R7 no req no stall", int'(stall), 0);
    while (!cmd_ready) @(negedge clk);
    check_result(1'b1, 3, 5);
    hi_rd_req = 1'b1; lo_rd_req = 1'b1;
    #0;
    check("R7 idle no stall", int'(stall), 0);
    hi_rd_req = 1'b0; lo_rd_req = 1'b0;

    // R3 commands offered while busy are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_signed = 1'b1; cmd_a = 4'd13; cmd_b = 4'd6;
    @(negedge clk);
    cmd_signed = 1'b0; cmd_a = 4'd15; cmd_b = 4'd15;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    check("R3 busy offer ignored lo", int'(lo_rd_data), (as_signed(13) * as_signed(6)) & MASK);
    check("R3 busy offer ignored hi", int'(hi_rd_data), ((as_signed(13) * as_signed(6)) >> W) & MASK);

    // R4 R5 R8 R9 exhaustive sweep in both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          issue(s[0], a, b, blen);
          if (blen != W + 1) check("R2 sweep busy len", blen, W + 1);
          check_result(s[0], a, b);
        end
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule